// File: doc/BRIEF.md
# Time-Shared Constant Twiddle Multiplier

This block rotates one complex sample (P, T) by a fixed twiddle factor whose real part C and imaginary part S are integers scaled by 1024 (ten fractional bits). It returns the rotated pair xb = P·C − T·S and yb = T·C + P·S, rounded back to the input scale. The multipliers are built from shifts and adds chosen by the one bits of each constant. No general multiplier is used. Each operand is turned into a magnitude and a sign before the shift-add tree, and the sign is put back on the product afterwards.

The block runs on a clock twice as fast as the surrounding adder stages. One pair of constant multipliers, one for C and one for S, is used twice per slow period. In the first fast cycle it forms P·C and T·S and latches them, together with P and T. In the second fast cycle it forms T·C and P·S from the latched operands. At the end of that cycle the latched products are subtracted to give xb and the fresh products are summed to give yb. Both results load in the same edge. A strobe that marks the first fast cycle of each slow period keeps the internal phase aligned; without it the phase simply alternates.

When the twiddle is exactly 1024 + 0j (zero angle), a parameter-selected variant replaces the arithmetic with plain registers that have the same latency.

Top module: `twiddle_mult_ts`

## Requirements
- R1: While arst_n is low, xb_o and yb_o are 0. The first clock edge after release is a first-phase (capture) edge even when lead_i is low.
- R2: xb_o equals floor((P·C − T·S + 512) / 1024), with C = TW_RE and S = TW_IM (defaults 993 and −249), for the P and T captured at a first-phase edge.
- R3: yb_o equals floor((T·C + P·S + 512) / 1024) for the same captured P and T.
- R4: p_i and t_i are captured at an edge where lead_i is high. Both results appear together right after the next edge, which is a second-phase edge.
- R5: xb_o and yb_o change only at second-phase edges and hold their values through the first-phase cycle. Without lead_i, the phases alternate every fast cycle.
- R6: Values on p_i and t_i during the second-phase cycle have no effect on the results of that period.
- R7: Every signed input is handled, including −2^(DATA_W−1) on both operands. No output magnitude exceeds (2^(DATA_W−1)·(|C|+|S|) + 512)/1024 + 1.
- R8: With TW_RE = 1024 and TW_IM = 0, xb_o equals P and yb_o equals T, sign-extended, with the same latency as R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| lead_i | input | 1 | High in the first fast cycle of a slow period |
| p_i | input | DATA_W | Signed real operand P |
| t_i | input | DATA_W | Signed imaginary operand T |
| xb_o | output | DATA_W+1 | Signed rotated real result |
| yb_o | output | DATA_W+1 | Signed rotated imaginary result |

## Verification
Both results are due one fast edge after the capture edge. The bench drives inputs on falling edges, raises lead_i for one cycle and compares at the falling edge that follows the second rising edge. It compares one cycle later again to confirm that nothing moved during the following first-phase cycle. Junk operands are driven during every second-phase cycle, so a design that reads the live inputs late gives wrong results. A unity-twiddle instance is driven in parallel and checked at the same sampling point. After reset, one pair is sent with no strobe at all, which checks the phase state that reset leaves behind.

// File: rtl/twm_pkg.sv
package twm_pkg;

  // Two fast-clock phases per slow period.
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;

  // The strobe forces the next cycle to be the second phase; otherwise alternate.
  function automatic phase_e next_phase(input phase_e cur, input logic lead);
    if (lead) return PH_SECOND;
    return (cur == PH_FIRST) ? PH_SECOND : PH_FIRST;
  endfunction

endpackage

// File: rtl/twm_const_mult.sv
module twm_const_mult #(
  parameter  int DATA_W = 12,
  parameter  int FRAC   = 10,
  parameter  int COEF   = 1024,
  localparam int COEF_W = FRAC + 1,
  localparam int PROD_W = DATA_W + COEF_W + 1
) (
  input  logic signed [DATA_W-1:0] op_i,
  output logic signed [PROD_W-1:0] prod_o
);

  localparam int UPROD_W  = DATA_W + COEF_W;
  localparam int COEF_ABS = (COEF < 0) ? -COEF : COEF;
  localparam bit COEF_NEG = (COEF < 0);
  localparam logic [COEF_W-1:0] COEF_BITS = COEF_W'(COEF_ABS);

  // Signed operand to unsigned magnitude (most negative value maps to 2^(DATA_W-1)).
  function automatic logic [DATA_W-1:0] magnitude(input logic signed [DATA_W-1:0] v);
    return v[DATA_W-1] ? DATA_W'(-v) : DATA_W'(v);
  endfunction

  // Unsigned product back to a signed value.
  function automatic logic signed [PROD_W-1:0] restore_sign(input logic [UPROD_W-1:0] m,
                                                            input logic neg);
    logic signed [PROD_W-1:0] s;
    s = $signed({1'b0, m});
    return neg ? -s : s;
  endfunction

  logic [DATA_W-1:0]  op_mag;
  logic [UPROD_W-1:0] partial [COEF_W];
  logic [UPROD_W-1:0] mag_prod;

  assign op_mag = magnitude(op_i);

  // One shifted copy per set bit of the constant; cleared bits contribute nothing.
  for (genvar gi = 0; gi < COEF_W; gi++) begin : g_bit
    if (COEF_BITS[gi]) begin : g_on
      assign partial[gi] = UPROD_W'(op_mag) << gi;
    end else begin : g_off
      assign partial[gi] = '0;
    end
  end

  always_comb begin
    mag_prod = '0;
    for (int i = 0; i < COEF_W; i++) mag_prod = mag_prod + partial[i];
  end

  assign prod_o = restore_sign(mag_prod, op_i[DATA_W-1] ^ COEF_NEG);

endmodule

// File: rtl/twm_phase.sv
module twm_phase (
  input  logic clk,
  input  logic arst_n,
  input  logic lead_i,
  output logic cap_fire_o,
  output logic out_fire_o
);
  import twm_pkg::*;

  phase_e phase_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) phase_q <= PH_FIRST;
    else         phase_q <= next_phase(phase_q, lead_i);
  end

  // A strobe always restarts the period as a first phase.
  assign out_fire_o = (phase_q == PH_SECOND) && !lead_i;
  assign cap_fire_o = !out_fire_o;

endmodule

// File: rtl/twm_shared_path.sv
module twm_shared_path #(
  parameter  int DATA_W = 12,
  parameter  int FRAC   = 10,
  parameter  int TW_RE  = 993,
  parameter  int TW_IM  = -249,
  localparam int OUT_W  = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     arst_n,
  input  logic                     cap_fire_i,
  input  logic                     out_fire_i,
  input  logic signed [DATA_W-1:0] p_i,
  input  logic signed [DATA_W-1:0] t_i,
  output logic signed [OUT_W-1:0]  xb_o,
  output logic signed [OUT_W-1:0]  yb_o
);

  localparam int PROD_W = DATA_W + FRAC + 2;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC - 1);

  function automatic logic signed [SUM_W-1:0] widen(input logic signed [PROD_W-1:0] v);
    return {v[PROD_W-1], v};
  endfunction

  // Round half up, then drop the fractional bits.
  function automatic logic signed [OUT_W-1:0] scale_round(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] biased;
    biased = s + HALF;
    biased = biased >>> FRAC;
    return biased[OUT_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] hold_p, hold_t;
  logic signed [PROD_W-1:0] part_pc, part_ts;
  logic signed [DATA_W-1:0] op_re, op_im;
  logic signed [PROD_W-1:0] prod_re, prod_im;
  logic signed [SUM_W-1:0]  x_sum, y_sum;

  // First phase: P*C and T*S. Second phase: T*C and P*S from the held operands.
  assign op_re = out_fire_i ? hold_t : p_i;
  assign op_im = out_fire_i ? hold_p : t_i;

  twm_const_mult #(.DATA_W(DATA_W), .FRAC(FRAC), .COEF(TW_RE)) u_mul_re (
    .op_i(op_re), .prod_o(prod_re)
  );

  twm_const_mult #(.DATA_W(DATA_W), .FRAC(FRAC), .COEF(TW_IM)) u_mul_im (
    .op_i(op_im), .prod_o(prod_im)
  );

  assign x_sum = widen(part_pc) - widen(part_ts);
  assign y_sum = widen(prod_re) + widen(prod_im);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_p  <= '0;
      hold_t  <= '0;
      part_pc <= '0;
      part_ts <= '0;
      xb_o    <= '0;
      yb_o    <= '0;
    end else begin
      if (cap_fire_i) begin
        hold_p  <= p_i;
        hold_t  <= t_i;
        part_pc <= prod_re;
        part_ts <= prod_im;
      end
      if (out_fire_i) begin
        xb_o <= scale_round(x_sum);
        yb_o <= scale_round(y_sum);
      end
    end
  end

endmodule

// File: rtl/twm_unity_path.sv
module twm_unity_path #(
  parameter  int DATA_W = 12,
  localparam int OUT_W  = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     arst_n,
  input  logic                     cap_fire_i,
  input  logic                     out_fire_i,
  input  logic signed [DATA_W-1:0] p_i,
  input  logic signed [DATA_W-1:0] t_i,
  output logic signed [OUT_W-1:0]  xb_o,
  output logic signed [OUT_W-1:0]  yb_o
);

  logic signed [DATA_W-1:0] hold_p, hold_t;

  // Same two-edge latency as the arithmetic path, no multiplication.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_p <= '0;
      hold_t <= '0;
      xb_o   <= '0;
      yb_o   <= '0;
    end else begin
      if (cap_fire_i) begin
        hold_p <= p_i;
        hold_t <= t_i;
      end
      if (out_fire_i) begin
        xb_o <= {hold_p[DATA_W-1], hold_p};
        yb_o <= {hold_t[DATA_W-1], hold_t};
      end
    end
  end

endmodule

// File: rtl/twiddle_mult_ts.sv
module twiddle_mult_ts #(
  parameter  int DATA_W = 12,
  parameter  int FRAC   = 10,
  parameter  int TW_RE  = 993,
  parameter  int TW_IM  = -249,
  localparam int OUT_W  = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     arst_n,
  input  logic                     lead_i,
  input  logic signed [DATA_W-1:0] p_i,
  input  logic signed [DATA_W-1:0] t_i,
  output logic signed [OUT_W-1:0]  xb_o,
  output logic signed [OUT_W-1:0]  yb_o
);

  localparam bit IS_UNITY = (TW_RE == (1 << FRAC)) && (TW_IM == 0);

  // Named phase events, also watched by the bound checker.
  logic cap_fire;
  logic out_fire;

  twm_phase u_phase (
    .clk       (clk),
    .arst_n    (arst_n),
    .lead_i    (lead_i),
    .cap_fire_o(cap_fire),
    .out_fire_o(out_fire)
  );

  if (IS_UNITY) begin : g_unity
    twm_unity_path #(.DATA_W(DATA_W)) u_path (
      .clk(clk), .arst_n(arst_n), .cap_fire_i(cap_fire), .out_fire_i(out_fire),
      .p_i(p_i), .t_i(t_i), .xb_o(xb_o), .yb_o(yb_o)
    );
  end else begin : g_rotate
    twm_shared_path #(.DATA_W(DATA_W), .FRAC(FRAC), .TW_RE(TW_RE), .TW_IM(TW_IM)) u_path (
      .clk(clk), .arst_n(arst_n), .cap_fire_i(cap_fire), .out_fire_i(out_fire),
      .p_i(p_i), .t_i(t_i), .xb_o(xb_o), .yb_o(yb_o)
    );
  end

endmodule

// File: rtl/twm_checker.sv
module twm_checker #(
  parameter  int DATA_W = 12,
  parameter  int FRAC   = 10,
  parameter  int TW_RE  = 993,
  parameter  int TW_IM  = -249,
  localparam int OUT_W  = DATA_W + 1
) (
  input logic                     clk,
  input logic                     arst_n,
  input logic                     lead_i,
  input logic                     out_fire,
  input logic signed [DATA_W-1:0] p_i,
  input logic signed [DATA_W-1:0] t_i,
  input logic signed [OUT_W-1:0]  xb_o,
  input logic signed [OUT_W-1:0]  yb_o
);

  localparam bit IS_UNITY = (TW_RE == (1 << FRAC)) && (TW_IM == 0);
  localparam longint ABS_SUM = longint'((TW_RE < 0) ? -TW_RE : TW_RE) +
                               longint'((TW_IM < 0) ? -TW_IM : TW_IM);
  localparam longint LIM = (((longint'(1) << (DATA_W - 1)) * ABS_SUM + 512) >>> FRAC) + 1;

  logic signed [OUT_W-1:0] p_ext, t_ext;
  assign p_ext = p_i;
  assign t_ext = t_i;

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !out_fire |=> ($stable(xb_o) && $stable(yb_o)));

  // R4
  lead_chk: assert property (@(posedge clk) disable iff (!arst_n)
    lead_i |=> (out_fire || lead_i));

  // R5
  alt_chk: assert property (@(posedge clk) disable iff (!arst_n)
    out_fire |=> !out_fire);

  // R7
  range_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (longint'(xb_o) <= LIM) && (longint'(xb_o) >= -LIM) &&
    (longint'(yb_o) <= LIM) && (longint'(yb_o) >= -LIM));

  // R8
  unity_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (IS_UNITY && $past(out_fire)) |-> (xb_o == $past(p_ext, 2) && yb_o == $past(t_ext, 2)));

endmodule

bind twiddle_mult_ts twm_checker #(
  .DATA_W(DATA_W), .FRAC(FRAC), .TW_RE(TW_RE), .TW_IM(TW_IM)
) i_chk (
  .clk(clk), .arst_n(arst_n), .lead_i(lead_i), .out_fire(out_fire),
  .p_i(p_i), .t_i(t_i), .xb_o(xb_o), .yb_o(yb_o)
);

// File: tb/test_twiddle_mult_ts.sv
module test_twiddle_mult_ts;

  localparam int DW = 12;
  localparam int OW = DW + 1;
  localparam int C  = 993;
  localparam int S  = -249;
  localparam int NV = 10;
  // Stimulus table: P and T per vector; expected results come from ref_scale.
  localparam int VP [NV] = '{2047, -2048, -2048, 0, 1, 0, 512, -1, 100, -777};
  localparam int VT [NV] = '{2047, -2048, 2047, 0, 0, 1, -300, -1, 200, 1234};

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic lead = 1'b0;
  logic signed [DW-1:0] p = '0;
  logic signed [DW-1:0] t = '0;
  logic signed [OW-1:0] x, y, xu, yu;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twiddle_mult_ts #(.DATA_W(DW), .FRAC(10), .TW_RE(C), .TW_IM(S)) i_twiddle_mult_ts (
    .clk(clk), .arst_n(arst_n), .lead_i(lead), .p_i(p), .t_i(t), .xb_o(x), .yb_o(y)
  );

  twiddle_mult_ts #(.DATA_W(DW), .FRAC(10), .TW_RE(1024), .TW_IM(0)) i_twiddle_mult_ts_unity (
    .clk(clk), .arst_n(arst_n), .lead_i(lead), .p_i(p), .t_i(t), .xb_o(xu), .yb_o(yu)
  );

  // Round-half-up division by 1024, written as floor division.
  function automatic longint ref_scale(input longint num);
    longint b;
    b = num + 512;
    if (b >= 0) return b / 1024;
    return -((-b + 1023) / 1024);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int pv, input int tv);
    longint hx, hy;
    @(negedge clk);
    p = DW'(pv); t = DW'(tv); lead = 1'b1;
    @(negedge clk);
    lead = 1'b0; p = ~p; t = ~t;           // second-phase junk (R6)
    @(negedge clk);
    check("R2 xb", longint'(x), ref_scale(longint'(pv) * C - longint'(tv) * S));
    check("R3 yb", longint'(y), ref_scale(longint'(tv) * C + longint'(pv) * S));
    check("R8 unity xb", longint'(xu), longint'(pv));
    check("R8 unity yb", longint'(yu), longint'(tv));
    hx = longint'(x); hy = longint'(y);
    @(negedge clk);
    check("R5 hold xb", longint'(x), hx);
    check("R5 hold yb", longint'(y), hy);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset xb", longint'(x), 0);
    check("R1 reset yb", longint'(y), 0);
    arst_n = 1'b1;

    // R2 R3 R4 R6 R7 R8: table walk, includes full-scale and most negative operands
    for (int i = 0; i < NV; i++) run_vec(VP[i], VT[i]);

    // R1: mid-run reset clears outputs
    run_vec(1500, -900);
    @(negedge clk);
    arst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset xb", longint'(x), 0);
    check("R1 mid reset yb", longint'(y), 0);

    // R1: first edge after release captures even without the strobe
    arst_n = 1'b1; lead = 1'b0;
    p = DW'(300); t = DW'(-100);
    @(negedge clk);
    p = DW'(-5); t = DW'(7);
    @(negedge clk);
    check("R1 phase xb", longint'(x), ref_scale(longint'(300) * C - longint'(-100) * S));
    check("R1 phase yb", longint'(y), ref_scale(longint'(-100) * C + longint'(300) * S));
    check("R1 phase unity xb", longint'(xu), 300);

    // R5: without strobe, the next pair lands two cycles later
    @(negedge clk);
    @(negedge clk);
    check("R5 alternate xb", longint'(x), ref_scale(longint'(-5) * C - longint'(7) * S));
    check("R5 alternate yb", longint'(y), ref_scale(longint'(7) * C + longint'(-5) * S));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule